// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast clock by a programmable integer N and emits a one-cycle pulse once per N input cycles. It is meant for the feedback path of a frequency synthesizer. The prescaler is modelled as a logic-rate counter, and it counts either P or P+1 input cycles per prescaler cycle. A coarse counter of B prescaler cycles sets the length of an output period. A swallow count A chooses how many of those B cycles, counted from the start of the period, use the longer P+1 modulus. The total ratio is therefore N = P*B + A.

A 3-bit mode code selects the prescaler value. It also selects between a fixed ratio, where A plays no part, and the dual-modulus scheme. The ratio settings are sampled only at the boundary between output periods, so reprogramming never cuts a period short. A setting the scheme cannot realise is reported, and the output is held low while it is in place. A synchronous clear restarts the counting from a fresh load of the settings.

Top module: `pll_fbdiv`

## Requirements
- R1: mode_i selects the prescaler. Fixed-ratio codes are 3'b000 (P=1), 3'b001 (P=2) and 3'b111 (P=3). Dual-modulus codes are 3'b010 (P=2), 3'b011 (P=4), 3'b100 (P=8), 3'b101 (P=16) and 3'b110 (P=32). The internal mode register resets to 3'b110.
- R2: In a dual-modulus mode with 1 <= B and A <= B, the period is N = P*B + A input cycles. The first A prescaler cycles of a period last P+1 cycles each, and the remaining cycles last P.
- R3: In a fixed-ratio mode, a_cnt_i has no effect (any value, including A > B, raises no error), and N = P*B.
- R4: pulse_o is high for exactly one clock per period. When settings are loaded at clock edge L, the pulses are seen after edges L+N, L+2N, and so on.
- R5: Different settings with the same N give the same pulse timing. For example, N=12 comes from fixed P=2 with B=6, dual 2/3 with A=0 and B=6, dual 4/5 with A=0 and B=3, fixed P=3 with B=4, and dual 2/3 with A=4 and B=4.
- R6: If the loaded settings are a dual-modulus mode with A > B, or any mode with B = 0, cfg_err_o is high and pulse_o stays low. While in error the inputs are reloaded every clock, so valid inputs load at the next edge and restart the count.
- R7: Inputs are sampled only at the edge that ends a period, or at the first edge after a clear or reset, or while in error. A change in the middle of a period takes effect only after that period's pulse.
- R8: sync_clr_i held high at an edge clears the counters and forces pulse_o and cfg_err_o low. The first edge with sync_clr_i low loads the inputs and starts a new period.
- R9: Under reset, pulse_o and cfg_err_o are low. The first edge after reset is released loads the inputs.
- R10: The extreme settings work. N=1 (fixed P=1, B=1) gives pulse_o high on every clock. A = B is accepted in a dual-modulus mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_clr_i | input | 1 | Synchronous clear of counters and restart |
| mode_i | input | 3 | Prescaler mode code |
| a_cnt_i | input | 6 | Swallow count A |
| b_cnt_i | input | 13 | Coarse count B |
| pulse_o | output | 1 | One-clock pulse per N input cycles |
| cfg_err_o | output | 1 | Loaded settings cannot be realised |

## Verification
The in-line assertions check the following on every cycle. The prescaler and coarse counters stay inside the loaded modulus and B. Both counters restart at each pulse. No pulse follows a cycle spent in error. A clear always leaves the output low with a load pending. The loaded settings never move except on a load. The exact period length can only be shown by the bench's scenarios. So can the equivalence of different settings, the deferral of mid-period changes, and recovery from an invalid setting. The bench predicts every pulse cycle from N = P*B + A and compares each one as it occurs.

// File: rtl/pll_fbdiv_pkg.sv
package pll_fbdiv_pkg;

  localparam int unsigned PRE_W = 6;  // holds P+1 up to 33

  typedef enum logic [2:0] {
    MODE_FIX1  = 3'b000,
    MODE_FIX2  = 3'b001,
    MODE_DM2   = 3'b010,
    MODE_DM4   = 3'b011,
    MODE_DM8   = 3'b100,
    MODE_DM16  = 3'b101,
    MODE_DM32  = 3'b110,
    MODE_FIX3  = 3'b111
  } pre_mode_e;

  typedef struct packed {
    logic [PRE_W-1:0] p;
    logic             dual;
  } pre_cfg_t;

  function automatic pre_cfg_t decode_mode(input logic [2:0] code);
    pre_cfg_t r;
    unique case (code)
      MODE_FIX1: r = '{p: 6'd1,  dual: 1'b0};
      MODE_FIX2: r = '{p: 6'd2,  dual: 1'b0};
      MODE_DM2:  r = '{p: 6'd2,  dual: 1'b1};
      MODE_DM4:  r = '{p: 6'd4,  dual: 1'b1};
      MODE_DM8:  r = '{p: 6'd8,  dual: 1'b1};
      MODE_DM16: r = '{p: 6'd16, dual: 1'b1};
      MODE_DM32: r = '{p: 6'd32, dual: 1'b1};
      default:   r = '{p: 6'd3,  dual: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pll_fbdiv_cfg.sv
module pll_fbdiv_cfg
  import pll_fbdiv_pkg::*;
#(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [2:0]       mode_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  output logic [PRE_W-1:0] p_o,
  output logic             dual_o,
  output logic [A_W-1:0]   a_o,
  output logic [B_W-1:0]   b_o,
  output logic             bad_o
);

  localparam int unsigned PAD_W = B_W - A_W;

  logic [2:0]     mode_q;
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  pre_cfg_t       dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_DM32;
      a_q    <= '0;
      b_q    <= B_W'(1);
    end else if (load_i) begin
      mode_q <= mode_i;
      a_q    <= a_i;
      b_q    <= b_i;
    end
  end

  always_comb begin
    dec    = decode_mode(mode_q);
    p_o    = dec.p;
    dual_o = dec.dual;
    a_o    = a_q;
    b_o    = b_q;
    // swallow count may not exceed coarse count; B=0 has no period
    bad_o  = (b_q == '0) || (dec.dual && ({{PAD_W{1'b0}}, a_q} > b_q));
  end

  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(mode_q) && $stable(a_q) && $stable(b_q)));

endmodule

// File: rtl/pll_fbdiv_count.sv
module pll_fbdiv_count
  import pll_fbdiv_pkg::*;
#(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] p_i,
  input  logic             dual_i,
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic             bad_i,
  output logic             load_o,
  output logic             pulse_o,
  output logic             err_o
);

  localparam int unsigned PAD_W = B_W - A_W;

  logic             pend_q;
  logic [PRE_W-1:0] pre_q;
  logic [B_W-1:0]   bidx_q;
  logic             pulse_q;
  logic             swallow;
  logic [PRE_W-1:0] modulus;
  logic             pre_wrap;
  logic             term;

  always_comb begin
    swallow  = dual_i && (bidx_q < {{PAD_W{1'b0}}, a_i});
    modulus  = p_i + PRE_W'(swallow);
    pre_wrap = (pre_q == modulus - PRE_W'(1));
    term     = !pend_q && !bad_i && pre_wrap && (bidx_q == b_i - B_W'(1));
    load_o   = !clr_i && (pend_q || bad_i || term);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b1;
      pre_q   <= '0;
      bidx_q  <= '0;
      pulse_q <= 1'b0;
    end else if (clr_i) begin
      pend_q  <= 1'b1;
      pre_q   <= '0;
      bidx_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= term;
      if (load_o) begin
        pend_q <= 1'b0;
        pre_q  <= '0;
        bidx_q <= '0;
      end else if (pre_wrap) begin
        pre_q  <= '0;
        bidx_q <= bidx_q + B_W'(1);
      end else begin
        pre_q  <= pre_q + PRE_W'(1);
      end
    end
  end

  assign pulse_o = pulse_q;
  assign err_o   = bad_i && !pend_q;

  assert_pre_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !bad_i) |-> (pre_q < modulus));

  assert_b_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !bad_i) |-> (bidx_q < b_i));

  assert_pulse_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |-> (pre_q == '0 && bidx_q == '0));

  assert_err_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad_i && !pend_q) |=> !pulse_q);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!pulse_q && pend_q && !err_o));

endmodule

// File: rtl/pll_fbdiv.sv
module pll_fbdiv
  import pll_fbdiv_pkg::*;
#(
  parameter int unsigned A_W = 6,
  parameter int unsigned B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sync_clr_i,
  input  logic [2:0]     mode_i,
  input  logic [A_W-1:0] a_cnt_i,
  input  logic [B_W-1:0] b_cnt_i,
  output logic           pulse_o,
  output logic           cfg_err_o
);

  logic             load;
  logic [PRE_W-1:0] p_val;
  logic             dual;
  logic [A_W-1:0]   a_val;
  logic [B_W-1:0]   b_val;
  logic             bad;

  pll_fbdiv_cfg #(.A_W(A_W), .B_W(B_W)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .mode_i (mode_i),
    .a_i    (a_cnt_i),
    .b_i    (b_cnt_i),
    .p_o    (p_val),
    .dual_o (dual),
    .a_o    (a_val),
    .b_o    (b_val),
    .bad_o  (bad)
  );

  pll_fbdiv_count #(.A_W(A_W), .B_W(B_W)) i_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (sync_clr_i),
    .p_i     (p_val),
    .dual_i  (dual),
    .a_i     (a_val),
    .b_i     (b_val),
    .bad_i   (bad),
    .load_o  (load),
    .pulse_o (pulse_o),
    .err_o   (cfg_err_o)
  );

  assert_err_no_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && $past(cfg_err_o)) |-> !pulse_o);

endmodule

// File: tb/test_pll_fbdiv.sv
module test_pll_fbdiv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b1;
  logic [2:0]  mode = 3'b000;
  logic [5:0]  a = '0;
  logic [12:0] b = 13'd1;
  logic        pulse;
  logic        err;

  int    cyc = 0;
  int    q[$];
  int    checks = 0;
  int    errors = 0;
  bit    mon_en = 1'b0;
  bit    done = 1'b0;
  string req = "R4";

  pll_fbdiv i_pll_fbdiv (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sync_clr_i (clr),
    .mode_i     (mode),
    .a_cnt_i    (a),
    .b_cnt_i    (b),
    .pulse_o    (pulse),
    .cfg_err_o  (err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every observed or expected pulse against the queue
  always @(negedge clk) begin
    if (mon_en) begin
      bit exp_p;
      exp_p = (q.size() > 0) && (q[0] == cyc);
      if (exp_p || pulse) begin
        checks++;
        if (pulse !== exp_p) begin
          errors++;
          $display("FAIL %s cycle %0d pulse_o=%0b expected %0b", req, cyc, pulse, exp_p);
        end
        if (exp_p) void'(q.pop_front());
      end
    end
  end

  function automatic int ratio(input logic [2:0] m, input int av, input int bv);
    int p;
    bit d;
    case (m)
      3'b000: begin p = 1;  d = 0; end
      3'b001: begin p = 2;  d = 0; end
      3'b010: begin p = 2;  d = 1; end
      3'b011: begin p = 4;  d = 1; end
      3'b100: begin p = 8;  d = 1; end
      3'b101: begin p = 16; d = 1; end
      3'b110: begin p = 32; d = 1; end
      default: begin p = 3; d = 0; end
    endcase
    return d ? p * bv + av : p * bv;
  endfunction

  task automatic check(input bit ok, input string r, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", r, cyc, act, expv);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
    #1;
  endtask

  task automatic push_pulses(input int base, input int n, input int k);
    for (int i = 1; i <= k; i++) q.push_back(base + i * n);
  endtask

  // clr is high on entry; drive settings, release, return load cycle
  task automatic start(input logic [2:0] m, input int av, input int bv, output int l);
    mode = m; a = 6'(av); b = 13'(bv);
    @(negedge clk); #1;
    clr = 1'b0;
    l = cyc + 1;
  endtask

  task automatic run(input string r, input logic [2:0] m, input int av, input int bv, input int k);
    int l, n;
    req = r;
    start(m, av, bv, l);
    n = ratio(m, av, bv);
    push_pulses(l, n, k);
    wait_cyc(l + 1);
    check(err == 1'b0, r, err, 0);
    wait_cyc(l + k * n);
    clr = 1'b1;
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int l, l2;
    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    check(pulse == 1'b0, "R9", pulse, 0);
    check(err == 1'b0, "R9", err, 0);
    // R9: first edge after reset loads (fixed P=2, B=3 -> N=6)
    mode = 3'b001; b = 13'd3; clr = 1'b0;
    rst_n = 1'b1;
    l = cyc + 1;
    req = "R9";
    mon_en = 1'b1;
    push_pulses(l, 6, 3);
    wait_cyc(l + 18);
    clr = 1'b1;

    // R3: fixed mode ignores A even when A > B
    run("R3", 3'b001, 7, 6, 3);
    // R5: equivalent settings for N=12
    run("R5", 3'b010, 0, 6, 3);
    run("R5", 3'b011, 0, 3, 3);
    run("R5", 3'b111, 0, 4, 3);
    // R1: each prescaler code
    run("R1", 3'b100, 3, 5, 2);
    run("R1", 3'b000, 0, 7, 3);
    // R2: dual-modulus with swallow
    run("R2", 3'b110, 5, 7, 2);
    run("R2", 3'b101, 63, 100, 2);
    // R10: N=1 and A==B
    run("R10", 3'b000, 0, 1, 8);
    run("R10", 3'b010, 4, 4, 3);

    // R7: mid-period change takes effect after the current pulse
    req = "R7";
    start(3'b011, 1, 2, l);          // N=9
    push_pulses(l, 9, 2);
    wait_cyc(l + 11);
    mode = 3'b001; a = 6'd0; b = 13'd2;  // N=4
    push_pulses(l + 18, 4, 2);
    wait_cyc(l + 26);
    clr = 1'b1;

    // R6: A > B in dual mode flags error, then recovers
    req = "R6";
    start(3'b011, 5, 3, l);
    wait_cyc(l + 2);
    check(err == 1'b1, "R6", err, 1);
    check(pulse == 1'b0, "R6", pulse, 0);
    wait_cyc(l + 4);
    check(err == 1'b1, "R6", err, 1);
    a = 6'd2;                         // 4*3+2 = 14
    l2 = l + 5;
    push_pulses(l2, 14, 2);
    wait_cyc(l2);
    check(err == 1'b0, "R6", err, 0);
    wait_cyc(l2 + 28);
    clr = 1'b1;
    // R6: B=0 is an error in any mode
    start(3'b001, 0, 0, l);
    wait_cyc(l + 3);
    check(err == 1'b1, "R6", err, 1);
    clr = 1'b1;
    @(negedge clk); #1;

    // R8: clear mid-period restarts the count
    req = "R8";
    start(3'b011, 0, 5, l);          // N=20
    push_pulses(l, 20, 1);
    wait_cyc(l + 30);
    clr = 1'b1;
    @(negedge clk); #1;
    check(pulse == 1'b0, "R8", pulse, 0);
    check(err == 1'b0, "R8", err, 0);
    clr = 1'b0;
    l2 = cyc + 1;
    push_pulses(l2, 20, 2);
    wait_cyc(l2 + 40);
    clr = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(q.size() == 0, "R4", q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule